// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Status Word

This block holds an 8-bit accumulator, an 8-bit operand register and a program status word. A one-cycle operation strobe runs one of five arithmetic operations on the accumulator and the operand register: add, add with carry, subtract with borrow, unsigned 8x8 multiply and unsigned 8/8 divide. Each operation rewrites the carry, auxiliary-carry and overflow flags. The meaning of overflow depends on the operation: a signed sign-change overflow, a product wider than one byte, or a zero divisor.

A parity bit in the status word follows the accumulator at all times. Software cannot write it. Two status bits select one of four register banks, and the block drives the direct base address of the selected bank. Two further status bits are general-purpose flags that only software changes. A plain special-function-register bus reads and writes the accumulator, the operand register and the status word. Reads are combinational. Writes take effect at the next clock edge.

Top module: `acc_alu_psw`

## Requirements
- R1: After reset the accumulator, the operand register and the status word all read 0x00, and `bank_base_o` reads 0x00.
- R2: A bus write takes effect at the next clock edge and goes to the accumulator at address 0xE0, the status word at 0xD0 or the operand register at 0xF0. `sfr_rdata` returns the addressed register in the same cycle, and returns 0x00 for any other address. Status word layout: bit7 carry (CY), bit6 auxiliary carry (AC), bit5 user flag F0, bits4:3 bank select, bit2 overflow (OV), bit1 user flag F1, bit0 parity.
- R3: With `op_go` high, `op_code` selects the operation: 1 add, 2 add with carry, 3 subtract with borrow, 4 multiply, 5 divide. Codes 0, 6 and 7 change nothing. Add computes A+B, and add with carry computes A+B+CY. CY is set on a carry out of bit 7, and AC is set on a carry from bit 3 into bit 4.
- R4: Subtract with borrow computes A-B-CY. CY is set when a borrow into bit 7 is needed, and AC is set when the low nibble needs a borrow from the high nibble.
- R5: For add, add with carry and subtract with borrow, OV is set exactly when the two's-complement result leaves the range -128..127.
- R6: Multiply writes the low byte of A*B to the accumulator and the high byte to the operand register. It sets OV when the high byte is nonzero and clears CY and AC.
- R7: Divide writes A/B to the accumulator and A mod B to the operand register, and clears OV, CY and AC. With B = 0 it sets OV, clears CY and AC, and leaves both registers unchanged.
- R8: Status bit 0 is 1 exactly when the accumulator holds an odd number of ones. Bus writes to bit 0 have no effect.
- R9: F0 and F1 change only through bus writes to the status word. Arithmetic operations leave them unchanged.
- R10: `bank_base_o` equals {3'b000, bank select, 3'b000}. This gives 0x00, 0x08, 0x10 or 0x18 for banks 0 to 3.
- R11: When a status-word write and an operation fall in the same cycle, the operation sets CY, AC and OV, and the bus sets F0, F1 and the bank select. When a bus write targets the accumulator or the operand register in the same cycle as an operation that writes that register, the operation's result is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_go | input | 1 | Operation strobe, one cycle per operation |
| op_code | input | 3 | Operation select (see R3) |
| sfr_wr | input | 1 | Bus write enable |
| sfr_addr | input | 8 | Bus address |
| sfr_wdata | input | 8 | Bus write data |
| sfr_rdata | output | 8 | Bus read data, combinational |
| acc_o | output | 8 | Accumulator contents |
| b_o | output | 8 | Operand register contents |
| psw_o | output | 8 | Status word contents |
| bank_base_o | output | 8 | Direct base address of the selected register bank |

## Verification
Every operation and every bus write shows up on `acc_o`, `b_o`, `psw_o` and `bank_base_o` one clock edge after it is presented. The parity bit and the bank base follow combinationally from the registered state. The bench drives stimulus on the falling edge and moves its reference model across the same rising edge. It then compares all four outputs at the next falling edge, which is exactly one register delay later. `sfr_rdata` has no register in its path, so the bench checks it in the same low phase in which the address is presented.

// File: rtl/acc_alu_psw.sv
module acc_alu_psw #(
  parameter logic [7:0] ACC_SFR = 8'hE0,
  parameter logic [7:0] PSW_SFR = 8'hD0,
  parameter logic [7:0] B_SFR   = 8'hF0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_go,
  input  logic [2:0] op_code,
  input  logic       sfr_wr,
  input  logic [7:0] sfr_addr,
  input  logic [7:0] sfr_wdata,
  output logic [7:0] sfr_rdata,
  output logic [7:0] acc_o,
  output logic [7:0] b_o,
  output logic [7:0] psw_o,
  output logic [7:0] bank_base_o
);
  localparam logic [2:0] OP_ADD  = 3'd1;
  localparam logic [2:0] OP_ADDC = 3'd2;
  localparam logic [2:0] OP_SUBB = 3'd3;
  localparam logic [2:0] OP_MUL  = 3'd4;
  localparam logic [2:0] OP_DIV  = 3'd5;

  logic [7:0] acc_q, b_q;
  logic       cy_q, ac_q, f0_q, ov_q, f1_q;
  logic [1:0] rs_q;

  wire do_add  = op_go && (op_code == OP_ADD || op_code == OP_ADDC);
  wire do_sub  = op_go && op_code == OP_SUBB;
  wire do_mul  = op_go && op_code == OP_MUL;
  wire do_div  = op_go && op_code == OP_DIV;
  wire do_flag = do_add || do_sub || do_mul || do_div;

  wire wr_acc = sfr_wr && sfr_addr == ACC_SFR;
  wire wr_psw = sfr_wr && sfr_addr == PSW_SFR;
  wire wr_b   = sfr_wr && sfr_addr == B_SFR;

  // add/subtract share one adder: A - B - c == A + ~B + ~c
  wire       cin_flag = (op_code == OP_ADDC || op_code == OP_SUBB) && cy_q;
  wire       ci       = do_sub ? ~cin_flag : cin_flag;
  wire [7:0] b_eff    = do_sub ? ~b_q : b_q;
  wire [4:0] lo_sum   = {1'b0, acc_q[3:0]} + {1'b0, b_eff[3:0]} + {4'd0, ci};
  wire [8:0] full_sum = {1'b0, acc_q} + {1'b0, b_eff} + {8'd0, ci};
  wire       as_cy    = do_sub ? ~full_sum[8] : full_sum[8];
  wire       as_ac    = do_sub ? ~lo_sum[4] : lo_sum[4];
  wire       as_ov    = (acc_q[7] == b_eff[7]) && (full_sum[7] != acc_q[7]);

  wire [15:0] prod     = acc_q * b_q;
  wire        div_zero = (b_q == 8'd0);
  wire [7:0]  quot     = div_zero ? 8'd0 : acc_q / b_q;
  wire [7:0]  rem      = div_zero ? 8'd0 : acc_q % b_q;

  wire parity = ^acc_q;

  assign acc_o       = acc_q;
  assign b_o         = b_q;
  assign psw_o       = {cy_q, ac_q, f0_q, rs_q, ov_q, f1_q, parity};
  assign bank_base_o = {3'b000, rs_q, 3'b000};

  always_comb begin
    if (sfr_addr == ACC_SFR)      sfr_rdata = acc_q;
    else if (sfr_addr == PSW_SFR) sfr_rdata = psw_o;
    else if (sfr_addr == B_SFR)   sfr_rdata = b_q;
    else                          sfr_rdata = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 8'h00;
      b_q   <= 8'h00;
      cy_q  <= 1'b0;
      ac_q  <= 1'b0;
      f0_q  <= 1'b0;
      rs_q  <= 2'b00;
      ov_q  <= 1'b0;
      f1_q  <= 1'b0;
    end else begin
      if (wr_acc) acc_q <= sfr_wdata;
      if (wr_b)   b_q   <= sfr_wdata;
      if (wr_psw) begin
        cy_q <= sfr_wdata[7];
        ac_q <= sfr_wdata[6];
        f0_q <= sfr_wdata[5];
        rs_q <= sfr_wdata[4:3];
        ov_q <= sfr_wdata[2];
        f1_q <= sfr_wdata[1];
      end
      if (do_add || do_sub) begin
        acc_q <= full_sum[7:0];
        cy_q  <= as_cy;
        ac_q  <= as_ac;
        ov_q  <= as_ov;
      end
      if (do_mul) begin
        acc_q <= prod[7:0];
        b_q   <= prod[15:8];
        cy_q  <= 1'b0;
        ac_q  <= 1'b0;
        ov_q  <= |prod[15:8];
      end
      if (do_div) begin
        cy_q <= 1'b0;
        ac_q <= 1'b0;
        ov_q <= div_zero;
        if (!div_zero) begin
          acc_q <= quot;
          b_q   <= rem;
        end
      end
    end
  end

  // R9
  user_flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_psw |=> $stable({f0_q, f1_q}));

  // R6
  mul_ov_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_mul |=> (ov_q == (b_q != 8'd0)) && !cy_q && !ac_q);

  // R7
  div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_div && div_zero && !wr_acc && !wr_b) |=> ov_q && $stable(acc_q) && $stable(b_q));

  // R7
  div_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_div |=> !cy_q && !ac_q);

  // R3
  idle_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!do_flag && !wr_psw) |=> $stable({cy_q, ac_q, ov_q}));

  // R8
  parity_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!do_flag && !wr_acc && !(do_div && !div_zero)) |=> $stable(psw_o[0]));
endmodule

// File: tb/acc_alu_psw_tb_top.sv
module acc_alu_psw_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_go = 1'b0;
  logic [2:0] op_code = 3'd0;
  logic       sfr_wr = 1'b0;
  logic [7:0] sfr_addr = 8'h00;
  logic [7:0] sfr_wdata = 8'h00;
  logic [7:0] sfr_rdata, acc_o, b_o, psw_o, bank_base_o;

  int vectors = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference state
  int m_a, m_b, m_cy, m_ac, m_f0, m_rs, m_ov, m_f1;

  always #5 clk = ~clk;

  acc_alu_psw dut_i (
    .clk(clk), .rst_n(rst_n), .op_go(op_go), .op_code(op_code),
    .sfr_wr(sfr_wr), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_rdata(sfr_rdata), .acc_o(acc_o), .b_o(b_o), .psw_o(psw_o),
    .bank_base_o(bank_base_o)
  );

  function automatic int ones(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return n;
  endfunction

  function automatic int sgn(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic int exp_psw();
    return (m_cy << 7) | (m_ac << 6) | (m_f0 << 5) | (m_rs << 3) |
           (m_ov << 2) | (m_f1 << 1) | (ones(m_a) % 2);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    check(req, "acc", int'(acc_o), m_a);
    check(req, "b", int'(b_o), m_b);
    check(req, "psw", int'(psw_o), exp_psw());
    check("R10", "bank_base", int'(bank_base_o), m_rs * 8);
  endtask

  // one cycle: drive at negedge, model across posedge, compare at next negedge
  task automatic step(input string req, input bit go, input int code,
                      input bit wr, input int addr, input int data);
    int na, nb, ncy, nac, nov, nf0, nrs, nf1, r, cin;
    bit flag_op, acc_op, b_op;
    op_go = go; op_code = code[2:0];
    sfr_wr = wr; sfr_addr = addr[7:0]; sfr_wdata = data[7:0];
    na = m_a; nb = m_b; ncy = m_cy; nac = m_ac; nov = m_ov;
    nf0 = m_f0; nrs = m_rs; nf1 = m_f1;
    flag_op = 0; acc_op = 0; b_op = 0;
    if (go) begin
      cin = (code == 2 || code == 3) ? m_cy : 0;
      case (code)
        1, 2: begin
          r = m_a + m_b + cin;
          na = r % 256; ncy = (r > 255);
          nac = ((m_a % 16) + (m_b % 16) + cin) > 15;
          r = sgn(m_a) + sgn(m_b) + cin;
          nov = (r > 127 || r < -128);
          flag_op = 1; acc_op = 1;
        end
        3: begin
          r = m_a - m_b - cin;
          na = (r + 256) % 256; ncy = (r < 0);
          nac = ((m_a % 16) - (m_b % 16) - cin) < 0;
          r = sgn(m_a) - sgn(m_b) - cin;
          nov = (r > 127 || r < -128);
          flag_op = 1; acc_op = 1;
        end
        4: begin
          r = m_a * m_b;
          na = r % 256; nb = r / 256; nov = (r > 255);
          ncy = 0; nac = 0;
          flag_op = 1; acc_op = 1; b_op = 1;
        end
        5: begin
          ncy = 0; nac = 0; flag_op = 1;
          if (m_b == 0) nov = 1;
          else begin
            na = m_a / m_b; nb = m_a % m_b; nov = 0;
            acc_op = 1; b_op = 1;
          end
        end
        default: ;
      endcase
    end
    if (wr && addr == 8'hE0 && !acc_op) na = data;
    if (wr && addr == 8'hF0 && !b_op) nb = data;
    if (wr && addr == 8'hD0) begin
      nf0 = (data >> 5) & 1; nrs = (data >> 3) & 3; nf1 = (data >> 1) & 1;
      if (!flag_op) begin
        ncy = (data >> 7) & 1; nac = (data >> 6) & 1; nov = (data >> 2) & 1;
      end
    end
    @(posedge clk);
    m_a = na; m_b = nb; m_cy = ncy; m_ac = nac; m_ov = nov;
    m_f0 = nf0; m_rs = nrs; m_f1 = nf1;
    @(negedge clk);
    op_go = 0; sfr_wr = 0;
    compare_all(req);
  endtask

  task automatic wr(input string req, input int addr, input int data);
    step(req, 0, 0, 1, addr, data);
  endtask

  task automatic op(input string req, input int code);
    step(req, 1, code, 0, 0, 0);
  endtask

  task automatic load(input string req, input int a, input int b, input int psw);
    wr(req, 8'hE0, a);
    wr(req, 8'hF0, b);
    wr(req, 8'hD0, psw);
  endtask

  task automatic rd(input string req, input int addr, input int exp);
    sfr_addr = addr[7:0];
    #1;
    check(req, "rdata", int'(sfr_rdata), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    m_a = 0; m_b = 0; m_cy = 0; m_ac = 0; m_f0 = 0; m_rs = 0; m_ov = 0; m_f1 = 0;
    repeat (3) @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1");

    // R2 bus access
    wr("R2", 8'hE0, 8'h5A);
    wr("R2", 8'hF0, 8'hC3);
    wr("R2", 8'hD0, 8'hE6);
    rd("R2", 8'hE0, 8'h5A);
    rd("R2", 8'hF0, 8'hC3);
    rd("R2", 8'hD0, exp_psw());
    rd("R2", 8'h42, 8'h00);

    // R3 add / add with carry
    load("R3", 8'hFF, 8'h01, 8'h00); op("R3", 1);
    load("R3", 8'h0F, 8'h01, 8'h00); op("R3", 1);
    load("R3", 8'h10, 8'h20, 8'h80); op("R3", 2);
    load("R3", 8'h10, 8'h20, 8'h80); op("R3", 1);
    // R5 signed overflow
    load("R5", 8'h7F, 8'h01, 8'h00); op("R5", 1);
    load("R5", 8'h80, 8'h80, 8'h00); op("R5", 1);
    load("R5", 8'h80, 8'h01, 8'h00); op("R5", 3);
    load("R5", 8'h7F, 8'hFF, 8'h00); op("R5", 3);
    // R4 subtract with borrow
    load("R4", 8'h00, 8'h01, 8'h00); op("R4", 3);
    load("R4", 8'h10, 8'h01, 8'h00); op("R4", 3);
    load("R4", 8'h05, 8'h05, 8'h80); op("R4", 3);
    // R6 multiply
    load("R6", 8'd16, 8'd16, 8'hC4); op("R6", 4);
    load("R6", 8'd15, 8'd17, 8'h04); op("R6", 4);
    load("R6", 8'hFF, 8'hFF, 8'h00); op("R6", 4);
    // R7 divide
    load("R7", 8'd200, 8'd7, 8'hC4); op("R7", 5);
    load("R7", 8'd9, 8'd0, 8'hC0); op("R7", 5);
    load("R7", 8'd3, 8'd9, 8'h00); op("R7", 5);
    // R3 unused codes
    load("R3", 8'h33, 8'h44, 8'hC4); op("R3", 0); op("R3", 6); op("R3", 7);
    // R8 parity, bus write to bit 0 ignored
    wr("R8", 8'hE0, 8'h01);
    wr("R8", 8'hD0, 8'h00);
    wr("R8", 8'hE0, 8'h03);
    wr("R8", 8'hD0, 8'h01);
    // R9 user flags survive arithmetic
    load("R9", 8'h22, 8'h11, 8'h22); op("R9", 1); op("R9", 4); op("R9", 3);
    // R10 bank select
    for (int k = 0; k < 4; k++) wr("R10", 8'hD0, k << 3);
    // R11 collisions
    load("R11", 8'hFF, 8'h01, 8'h00);
    step("R11", 1, 1, 1, 8'hD0, 8'h3E);
    step("R11", 1, 4, 1, 8'hE0, 8'h99);
    step("R11", 1, 4, 1, 8'hF0, 8'h77);
    wr("R11", 8'hF0, 0);
    step("R11", 1, 5, 1, 8'hE0, 8'hA5);

    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      int code, addr_sel, addr;
      code = $urandom_range(7);
      addr_sel = $urandom_range(3);
      addr = (addr_sel == 0) ? 8'hE0 : (addr_sel == 1) ? 8'hD0 : (addr_sel == 2) ? 8'hF0 : 8'h12;
      step((code == 0) ? "R2" : (code <= 2) ? "R3" : (code == 3) ? "R4" : (code == 4) ? "R6" : "R7",
           $urandom_range(1) == 1, code, $urandom_range(1) == 1, addr, $urandom_range(255));
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule